// File: doc/BRIEF.md
# Wide Significand Normalizer

This block takes an unpacked floating-point operand (a 128-bit significand, a 32-bit signed exponent, a class tag, a sign and round/sticky flags) and returns it in canonical form. For an operand tagged normal, the significand is moved so that its most significant set bit sits at bit 112, which is the hidden-bit position of a 113-bit extended significand. The exponent is adjusted by the same distance. A normal operand whose significand is all zero is retagged as zero. Every other class goes through untouched.

The block is meant to sit after an arithmetic step whose raw result may carry its leading one anywhere in the 128 bits. A combinational leading-one detector measures the distance to bit 112. A logarithmic shifter then moves the significand in one direction or the other. The result is captured in a single output register stage, and a valid strobe travels alongside the data.

Top module: `wide_normalizer`

## Requirements
- R1: Class codes are zero=0, normal=1, infinity=2, quiet NaN=3 and signaling NaN=4. An operand whose class is not normal leaves with its significand, exponent and class exactly as they entered.
- R2: A normal operand with an all-zero significand leaves with class zero, and its significand and exponent are unchanged.
- R3: Every result that leaves tagged normal has bit 112 set and bits 127 to 113 clear. Its top 32-bit word is therefore in 0x00010000..0x0001FFFF.
- R4: When the top 32-bit word is zero, the significand moves up by whole words with zero fill, and the exponent drops by 32 for each word moved, before any bit-level step.
- R5: When the top word is 0x00020000 or larger, the significand moves right by the smallest n that puts the top word below 0x00020000, and n is added to the exponent. The bits that fall off the bottom are discarded, and the round and sticky outputs are not changed by them.
- R6: When the top word is nonzero but below 0x00010000 (possibly after the word steps of R4), the significand moves left by the smallest n that lifts the top word to 0x00010000 or above. Zeros enter at the bottom, and n is subtracted from the exponent.
- R7: A normal operand whose top word is already in 0x00010000..0x0001FFFF leaves unchanged.
- R8: The exponent is 32-bit two's complement, and every adjustment wraps modulo 2^32 with no saturation.
- R9: The sign, round and sticky bits leave equal to the values that came in.
- R10: A result appears on the outputs on the clock edge after the edge that accepts an operand, and out_valid equals in_valid delayed by one cycle. While in_valid is low, the data outputs keep their last values. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign |
| in_class | input | 3 | Operand class code |
| in_exp | input | 32 | Operand exponent, two's complement |
| in_sig | input | 128 | Operand significand |
| in_round | input | 1 | Operand round bit |
| in_sticky | input | 1 | Operand sticky bit |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Result sign |
| out_class | output | 3 | Result class code |
| out_exp | output | 32 | Result exponent |
| out_sig | output | 128 | Result significand |
| out_round | output | 1 | Result round bit |
| out_sticky | output | 1 | Result sticky bit |

## Verification
Random significands are shifted right by a random amount, so the leading one lands at positions spread over all 128 bits. This exercises word-step-plus-left cases, pure left cases within the top word, and right cases. Each outcome is compared against a loop-based reference that steps word by word and then bit by bit. Directed operands cover the ends of the range: a single bit at position 0, a full top word, a significand that is already normalized, an all-zero normal and every non-normal class. Two further operands pick out the wrapping exponent and the right shift that discards bits while round and sticky stay unchanged. A bubble in the valid strobe separates the latency behaviour from the data hold.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fpn_lead_one.sv
module fpn_lead_one #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int SIG_W    = WORD_W * NUM_WORDS,
  localparam int POS_W    = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0] sig_i,
  output logic [POS_W-1:0] pos_o,
  output logic             any_o
);
  localparam int BW = $clog2(WORD_W);

  logic [NUM_WORDS-1:0]    word_nz;
  logic [NUM_WORDS*BW-1:0] word_pos;

  // per-word priority encoders, highest set bit wins
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [BW-1:0] p;
    assign word_nz[w] = |sig_i[w*WORD_W +: WORD_W];
    always_comb begin
      p = '0;
      for (int b = 0; b < WORD_W; b++)
        if (sig_i[w*WORD_W + b]) p = BW'(b);
    end
    assign word_pos[w*BW +: BW] = p;
  end

  // pick the most significant nonzero word
  always_comb begin
    any_o = 1'b0;
    pos_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_nz[w]) begin
        any_o = 1'b1;
        pos_o = POS_W'(w * WORD_W) + POS_W'(word_pos[w*BW +: BW]);
      end
    end
  end
endmodule

// File: rtl/fpn_shift.sv
module fpn_shift #(
  parameter int SIG_W = 128,
  localparam int AMT_W = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] stg [0:AMT_W];

  assign stg[0] = sig_i;

  // one mux level per amount bit; vacated positions fill with zero
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = !amt_i[k] ? stg[k]
                    : right_i   ? (stg[k] >> STEP)
                                : (stg[k] << STEP);
  end

  assign sig_o = stg[AMT_W];
endmodule

// File: rtl/wide_normalizer.sv
module wide_normalizer #(
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 4,
  parameter int EXP_W      = 32,
  parameter int TARGET_BIT = 112,
  localparam int SIG_W     = WORD_W * NUM_WORDS,
  localparam int POS_W     = $clog2(SIG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [2:0]       in_class,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_round,
  input  logic             in_sticky,
  output logic             out_valid,
  output logic             out_sign,
  output logic [2:0]       out_class,
  output logic [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_round,
  output logic             out_sticky
);
  import fpn_pkg::*;

  localparam logic [POS_W-1:0] TGT = POS_W'(TARGET_BIT);

  logic [POS_W-1:0] lead_pos;
  logic             lead_any;
  logic             go_right;
  logic [POS_W-1:0] shamt;
  logic [SIG_W-1:0] shifted;
  logic [EXP_W-1:0] exp_adj;
  logic             is_normal;

  fpn_lead_one #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_lod (
    .sig_i (in_sig),
    .pos_o (lead_pos),
    .any_o (lead_any)
  );

  // distance from the leading one to the target bit, either direction
  assign go_right = lead_pos > TGT;
  assign shamt    = go_right ? (lead_pos - TGT) : (TGT - lead_pos);

  fpn_shift #(.SIG_W(SIG_W)) u_shift (
    .sig_i   (in_sig),
    .amt_i   (shamt),
    .right_i (go_right),
    .sig_o   (shifted)
  );

  // exponent moves by (lead position - target), wrapping
  assign exp_adj   = in_exp + EXP_W'(lead_pos) - EXP_W'(TGT);
  assign is_normal = in_class == CLS_NORMAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sign   <= 1'b0;
      out_class  <= CLS_ZERO;
      out_exp    <= '0;
      out_sig    <= '0;
      out_round  <= 1'b0;
      out_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign   <= in_sign;
        out_round  <= in_round;
        out_sticky <= in_sticky;
        if (is_normal && lead_any) begin
          out_class <= CLS_NORMAL;
          out_exp   <= exp_adj;
          out_sig   <= shifted;
        end else begin
          out_class <= is_normal ? CLS_ZERO : in_class;
          out_exp   <= in_exp;
          out_sig   <= in_sig;
        end
      end
    end
  end

  // R3: normalized results carry the leading one at the target bit
  p_lead_at_target_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_NORMAL) |->
      (out_sig[TARGET_BIT] && out_sig[SIG_W-1:TARGET_BIT+1] == '0));

  // R1: non-normal operands pass through unchanged
  p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class != CLS_NORMAL) |=>
      (out_sig == $past(in_sig) && out_exp == $past(in_exp) &&
       out_class == $past(in_class)));

  // R2: an all-zero normal becomes zero with data kept
  p_zero_reclass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == CLS_NORMAL && in_sig == '0) |=>
      (out_class == CLS_ZERO && out_sig == '0 && out_exp == $past(in_exp)));

  // R9: sign, round and sticky are carried through
  p_flags_kept_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sign == $past(in_sign) && out_round == $past(in_round) &&
                  out_sticky == $past(in_sticky)));

  // R10: valid follows input after one cycle; data holds on a bubble
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_hold_on_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sig) && $stable(out_exp)));
endmodule

// File: tb/wide_normalizer_tb.sv
`timescale 1ns/1ps
module wide_normalizer_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_sign, in_round, in_sticky;
  logic [2:0]   in_class;
  logic [31:0]  in_exp;
  logic [127:0] in_sig;
  logic         out_valid, out_sign, out_round, out_sticky;
  logic [2:0]   out_class;
  logic [31:0]  out_exp;
  logic [127:0] out_sig;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wide_normalizer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_class(in_class), .in_exp(in_exp), .in_sig(in_sig),
    .in_round(in_round), .in_sticky(in_sticky), .out_valid(out_valid),
    .out_sign(out_sign), .out_class(out_class), .out_exp(out_exp),
    .out_sig(out_sig), .out_round(out_round), .out_sticky(out_sticky)
  );

  task automatic chk(input bit ok, input string req, input logic [162:0] act,
                     input logic [162:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // reference: word steps, then single-bit steps
  function automatic logic [162:0] ref_norm(input logic [2:0] c,
      input logic [31:0] e, input logic [127:0] s);
    logic [127:0] g = s;
    logic [31:0]  x = e;
    if (c != 3'd1) return {c, e, s};
    if (g == '0) return {3'd0, e, s};
    while (g[127:96] == 32'd0) begin g = g << 32; x = x - 32; end
    while (g[127:96] >= 32'h0002_0000) begin g = g >> 1; x = x + 1; end
    while (g[127:96] <  32'h0001_0000) begin g = g << 1; x = x - 1; end
    return {3'd1, x, g};
  endfunction

  function automatic string req_of(input logic [2:0] c, input logic [127:0] s);
    if (c != 3'd1) return "R1";
    if (s == '0) return "R2";
    if (s[127:96] == 32'd0) return "R4";
    if (s[127:96] >= 32'h0002_0000) return "R5";
    if (s[127:96] <  32'h0001_0000) return "R6";
    return "R7";
  endfunction

  task automatic apply(input logic sg, input logic [2:0] c, input logic [31:0] e,
                       input logic [127:0] s, input logic r, input logic st,
                       input string tag);
    logic [162:0] expv;
    in_valid = 1'b1; in_sign = sg; in_class = c; in_exp = e; in_sig = s;
    in_round = r; in_sticky = st;
    expv = ref_norm(c, e, s);
    @(negedge clk);
    chk(out_valid && {out_class, out_exp, out_sig} == expv,
        (tag != "") ? tag : req_of(c, s), {out_class, out_exp, out_sig}, expv);
    chk({out_sign, out_round, out_sticky} == {sg, r, st}, "R9",
        163'({out_sign, out_round, out_sticky}), 163'({sg, r, st}));
    if (out_class == 3'd1)
      chk(out_sig[112] && out_sig[127:113] == '0, "R3", 163'(out_sig), 163'(1) << 112);
  endtask

  initial begin
    logic [162:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_class = 3'd0;
    in_exp = '0; in_sig = '0; in_round = 1'b0; in_sticky = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset", 163'(out_valid), 163'(0));
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    apply(1'b1, 3'd2, 32'h7F, {32'hFFFF_0000, 96'h5}, 1'b1, 1'b0, "R1 inf");
    apply(1'b0, 3'd3, 32'h10, {32'h0, 96'h1}, 1'b0, 1'b1, "R1 qnan");
    apply(1'b0, 3'd4, 32'h20, {32'h8000_0000, 96'h0}, 1'b1, 1'b1, "R1 snan");
    apply(1'b0, 3'd0, 32'h33, 128'h9, 1'b0, 1'b0, "R1 zero");
    apply(1'b1, 3'd1, 32'h1234, 128'h0, 1'b0, 1'b1, "R2");
    apply(1'b0, 3'd1, 32'h100, {32'h0001_8000, 96'hABC}, 1'b0, 1'b0, "R7");
    apply(1'b0, 3'd1, 32'h100, {32'hFFFF_FFFF, 96'hFFFF}, 1'b0, 1'b0, "R5 full");
    apply(1'b0, 3'd1, 32'h0, {32'h0002_0000, 96'h7}, 1'b0, 1'b0, "R5 discard");
    apply(1'b0, 3'd1, 32'h500, {32'h0000_0123, 96'h1}, 1'b0, 1'b0, "R6");
    apply(1'b0, 3'd1, 32'h500, {96'h0, 32'h0001_0000}, 1'b0, 1'b0, "R4 three");
    apply(1'b0, 3'd1, 32'h0, 128'h1, 1'b1, 1'b1, "R4 R6 bit0");
    apply(1'b0, 3'd1, 32'h8000_0000, 128'h1, 1'b0, 1'b0, "R8 wrap");
    apply(1'b0, 3'd1, 32'h7FFF_FFFF, {32'h8000_0000, 96'h0}, 1'b0, 1'b0, "R8 wrap up");

    // bubble: valid drops, data held (R10)
    held = {out_class, out_exp, out_sig};
    in_valid = 1'b0; in_sig = 128'hDEAD; in_class = 3'd1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid", 163'(out_valid), 163'(0));
    chk({out_class, out_exp, out_sig} == held, "R10 hold",
        {out_class, out_exp, out_sig}, held);

    // random operands, leading one spread over all positions
    for (int i = 0; i < 600; i++) begin
      logic [127:0] s;
      logic [2:0]   c;
      s = {$urandom, $urandom, $urandom, $urandom} >> ($urandom % 128);
      c = (($urandom % 8) == 0) ? 3'($urandom % 5) : 3'd1;
      apply(1'($urandom), c, $urandom, s, 1'($urandom), 1'($urandom), "");
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule